// File: doc/BRIEF.md
# UART interrupt identification unit

This block sits beside one UART channel and decides which of its interrupt sources is reported to the processor. It takes the enable bits, the fill levels of the receive and transmit FIFOs, the transmit shift-register empty flag, the receive error events, a receive-timeout event and the modem, XOFF and flow-control events. From these it builds an identification byte, an interrupt request line, a line status byte and a supplementary status byte. FIFO storage, serialization and register decode stay outside; the bus side only delivers read and write strobes for the registers whose access clears a source.

Seven sources are ranked, from highest to lowest: line-status error, receive timeout, receive data at trigger, transmit space, modem status, XOFF detected and flow-control change. Event sources are caught in sticky flags that are set whatever the enable bits hold; the enable bits only gate what is reported. Level sources (receive data) are compared every cycle against a programmable threshold. The transmit source is raised on entry into its condition and can optionally wait until the shift register has drained too.

Top module: `uart_irq_ident`

## Requirements
- R1: Identification bit 0 is 0 while any enabled source is pending and 1 otherwise; `irq` is its inverse; with nothing pending bits 5:1 read 0 (byte 0x01 or 0xC1).
- R2: Bits 5:0 of the identification byte carry the code of the highest pending source in the order line-status 0x06, receive timeout 0x0C, receive data 0x04, transmit 0x02, modem 0x00, XOFF 0x10, flow change 0x20.
- R3: Identification bits 7 and 6 both equal `fifo_en`.
- R4: `irq_en` bit 0 gates receive data and receive timeout, bit 1 transmit, bit 2 line status, bit 3 modem, bit 4 XOFF, bit 5 flow change; an event arriving while disabled is not reported but stays latched until cleared.
- R5: With `fifo_en` set, receive data is pending when `rx_level` reaches the threshold chosen by `rx_trig_sel` (0:8, 1:16, 2:DEPTH-8, 3:DEPTH-4, i.e. 60 at depth 64); with `fifo_en` clear, when `rx_level` is at least 1.
- R6: The transmit condition is, with `fifo_en` set, free spaces (DEPTH minus `tx_level`) at least the `tx_trig_sel` threshold (0:8, 1:16, 2:32, 3:DEPTH-8, i.e. 56); with `fifo_en` clear, `tx_level` equal to 0; the source is raised on the cycle after the enabled condition becomes true and is cleared by `thr_wr` or by `iir_rd` while it is the reported source.
- R7: With `tx_drain_mode` set, the transmit condition is instead `tx_level` equal to 0 and `tx_shift_empty` high.
- R8: Line status bits: 0 receive data present, 1 overrun, 2 parity, 3 framing, 4 break (bits 1 to 4 sticky), 5 TX FIFO empty, 6 TX FIFO and shift register empty, 7 `rx_fifo_err`.
- R9: `lsr_rd` clears bits 1 to 4 and the line-status source on the next cycle; an error event in the same cycle as the read stays set.
- R10: A receive-timeout pulse is latched and cleared by `rx_rd` or by an empty receive FIFO.
- R11: The modem source clears on `msr_rd`; the XOFF and flow-change sources clear on `iir_rd` while they are the reported source.
- R12: Supplementary status bit 0 is 1 exactly when `tx_level` equals DEPTH; bits 7:1 are 0.
- R13: Event pulses show in the outputs one cycle after the pulse edge; level inputs show in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 6 | Source enable bits |
| fifo_en | input | 1 | FIFO mode on |
| rx_trig_sel | input | 2 | Receive threshold select |
| tx_trig_sel | input | 2 | Transmit free-space threshold select |
| tx_drain_mode | input | 1 | Transmit source waits for shift register empty |
| rx_level | input | 7 | Characters held in receive FIFO |
| tx_level | input | 7 | Characters held in transmit FIFO |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_framing | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break event pulse |
| rx_fifo_err | input | 1 | Some character in receive FIFO has an error |
| rx_timeout | input | 1 | Receive timeout event pulse |
| modem_evt | input | 1 | Modem status change pulse |
| xoff_evt | input | 1 | XOFF character detected pulse |
| flow_evt | input | 1 | Flow-control state change pulse |
| iir_rd | input | 1 | Identification byte read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| rx_rd | input | 1 | Receive data read strobe |
| thr_wr | input | 1 | Transmit data write strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |
| lsr | output | 8 | Line status byte |
| ssr | output | 8 | Supplementary status byte |

## Verification
A sticky flag that fails to set or clear shows in the identification byte one cycle after the pulse or strobe that should have moved it, either as a missing code or as a lower-ranked code hidden behind it; the bench stacks several sources so that a wrong priority order changes the reported code at once. A wrong threshold shows in the same cycle the level crosses it, so levels are stepped one below and exactly at each tested boundary. A transmit latch that misses its entry edge or ignores its clear is seen on the next cycle, including in drain mode where the shift flag alone makes the change.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NSRC = 7;

   // source rank, 0 is the highest
   typedef enum int {
      SRC_LINE    = 0,
      SRC_TIMEOUT = 1,
      SRC_RXDATA  = 2,
      SRC_TX      = 3,
      SRC_MODEM   = 4,
      SRC_XOFF    = 5,
      SRC_FLOW    = 6
   } src_e;

   // bits 5:1 of the identification byte for a source
   function automatic logic [4:0] src_field(int idx);
      case (idx)
         SRC_LINE:    return 5'h03;
         SRC_TIMEOUT: return 5'h06;
         SRC_RXDATA:  return 5'h02;
         SRC_TX:      return 5'h01;
         SRC_MODEM:   return 5'h00;
         SRC_XOFF:    return 5'h08;
         default:     return 5'h10;
      endcase
   endfunction

   function automatic int rx_threshold(logic [1:0] sel, int depth);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return depth - 8;
         default: return depth - 4;
      endcase
   endfunction

   function automatic int tx_threshold(logic [1:0] sel, int depth);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 16;
         2'd2:    return 32;
         default: return depth - 8;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig import uart_irq_pkg::*; #(
   parameter int DEPTH     = 64,
   parameter bit HAS_DRAIN = 1'b1,
   localparam int LVL_W    = $clog2(DEPTH + 1)
) (
   input  logic             fifo_en,
   input  logic [1:0]       rx_trig_sel,
   input  logic [1:0]       tx_trig_sel,
   input  logic             tx_drain_mode,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             tx_shift_empty,
   output logic             rx_hit,
   output logic             rx_nonempty,
   output logic             tx_cond,
   output logic             tx_empty,
   output logic             tx_full
);
   logic [LVL_W-1:0] tx_free;
   logic             tx_space_ok;
   logic             tx_normal;

   assign tx_free     = LVL_W'(DEPTH) - tx_level;
   assign rx_nonempty = (rx_level != '0);
   assign tx_empty    = (tx_level == '0);
   assign tx_full     = (tx_level == LVL_W'(DEPTH));

   always_comb begin
      if (fifo_en)
         rx_hit = (int'(rx_level) >= rx_threshold(rx_trig_sel, DEPTH));
      else
         rx_hit = rx_nonempty;
   end

   assign tx_space_ok = (int'(tx_free) >= tx_threshold(tx_trig_sel, DEPTH));
   assign tx_normal   = fifo_en ? tx_space_ok : tx_empty;

   generate
      if (HAS_DRAIN) begin : g_drain
         assign tx_cond = tx_drain_mode ? (tx_empty & tx_shift_empty) : tx_normal;
      end else begin : g_nodrain
         logic unused_drain;
         assign unused_drain = tx_drain_mode ^ tx_shift_empty;
         assign tx_cond = tx_normal;
      end
   endgenerate
endmodule

// File: rtl/uart_irq_evlatch.sv
module uart_irq_evlatch #(
   parameter int NEV = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set,
   input  logic [NEV-1:0] clr,
   output logic [NEV-1:0] q
);
   generate
      for (genvar g = 0; g < NEV; g++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[g] <= 1'b0;
            else if (set[g])
               q[g] <= 1'b1;
            else if (clr[g])
               q[g] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio import uart_irq_pkg::*; #(
   parameter int N = NSRC
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic [4:0]   field,
   output logic         pending
);
   always_comb begin
      grant   = '0;
      field   = 5'h00;
      pending = |req;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            field    = src_field(i);
         end
      end
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident import uart_irq_pkg::*; #(
   parameter int DEPTH     = 64,
   parameter bit HAS_DRAIN = 1'b1,
   localparam int LVL_W    = $clog2(DEPTH + 1),
   localparam int NEV      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [5:0]       irq_en,
   input  logic             fifo_en,
   input  logic [1:0]       rx_trig_sel,
   input  logic [1:0]       tx_trig_sel,
   input  logic             tx_drain_mode,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             tx_shift_empty,
   input  logic             err_overrun,
   input  logic             err_parity,
   input  logic             err_framing,
   input  logic             err_break,
   input  logic             rx_fifo_err,
   input  logic             rx_timeout,
   input  logic             modem_evt,
   input  logic             xoff_evt,
   input  logic             flow_evt,
   input  logic             iir_rd,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   input  logic             rx_rd,
   input  logic             thr_wr,
   output logic [7:0]       iir,
   output logic             irq,
   output logic [7:0]       lsr,
   output logic [7:0]       ssr
);
   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_irq_ident: DEPTH must be a power of two of at least 16");
      end
   endgenerate

   // event slots
   localparam int EV_OVR = 0, EV_PAR = 1, EV_FRM = 2, EV_BRK = 3;
   localparam int EV_TMO = 4, EV_MDM = 5, EV_XOF = 6, EV_FLW = 7;

   logic            rx_hit, rx_nonempty, tx_cond, tx_empty, tx_full;
   logic [NEV-1:0]  ev_set, ev_clr, ev_q;
   logic [NSRC-1:0] req, grant;
   logic [4:0]      field;
   logic            pending;
   logic            tx_arm, tx_arm_q, tx_pend;

   uart_irq_trig #(.DEPTH(DEPTH), .HAS_DRAIN(HAS_DRAIN)) u_trig (
      .fifo_en        (fifo_en),
      .rx_trig_sel    (rx_trig_sel),
      .tx_trig_sel    (tx_trig_sel),
      .tx_drain_mode  (tx_drain_mode),
      .rx_level       (rx_level),
      .tx_level       (tx_level),
      .tx_shift_empty (tx_shift_empty),
      .rx_hit         (rx_hit),
      .rx_nonempty    (rx_nonempty),
      .tx_cond        (tx_cond),
      .tx_empty       (tx_empty),
      .tx_full        (tx_full)
   );

   assign ev_set = {flow_evt, xoff_evt, modem_evt, rx_timeout,
                    err_break, err_framing, err_parity, err_overrun};

   always_comb begin
      ev_clr         = '0;
      ev_clr[EV_OVR] = lsr_rd;
      ev_clr[EV_PAR] = lsr_rd;
      ev_clr[EV_FRM] = lsr_rd;
      ev_clr[EV_BRK] = lsr_rd;
      ev_clr[EV_TMO] = rx_rd | ~rx_nonempty;
      ev_clr[EV_MDM] = msr_rd;
      ev_clr[EV_XOF] = iir_rd & grant[SRC_XOFF];
      ev_clr[EV_FLW] = iir_rd & grant[SRC_FLOW];
   end

   uart_irq_evlatch #(.NEV(NEV)) u_ev (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .clr   (ev_clr),
      .q     (ev_q)
   );

   // transmit source: raised on entry into the enabled condition
   assign tx_arm = irq_en[1] & tx_cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_arm_q <= 1'b0;
         tx_pend  <= 1'b0;
      end else begin
         tx_arm_q <= tx_arm;
         if (!tx_arm)
            tx_pend <= 1'b0;
         else if (!tx_arm_q)
            tx_pend <= 1'b1;
         else if (thr_wr || (iir_rd && grant[SRC_TX]))
            tx_pend <= 1'b0;
      end
   end

   always_comb begin
      req              = '0;
      req[SRC_LINE]    = irq_en[2] & (|ev_q[EV_BRK:EV_OVR]);
      req[SRC_TIMEOUT] = irq_en[0] & ev_q[EV_TMO];
      req[SRC_RXDATA]  = irq_en[0] & rx_hit;
      req[SRC_TX]      = irq_en[1] & tx_pend;
      req[SRC_MODEM]   = irq_en[3] & ev_q[EV_MDM];
      req[SRC_XOFF]    = irq_en[4] & ev_q[EV_XOF];
      req[SRC_FLOW]    = irq_en[5] & ev_q[EV_FLW];
   end

   uart_irq_prio #(.N(NSRC)) u_prio (
      .req     (req),
      .grant   (grant),
      .field   (field),
      .pending (pending)
   );

   assign iir = {fifo_en, fifo_en, field, ~pending};
   assign irq = pending;
   assign lsr = {rx_fifo_err, tx_empty & tx_shift_empty, tx_empty,
                 ev_q[EV_BRK], ev_q[EV_FRM], ev_q[EV_PAR], ev_q[EV_OVR],
                 rx_nonempty};
   assign ssr = {7'b0, tx_full};
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int DEPTH  = 64,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [5:0]       irq_en,
   input logic             fifo_en,
   input logic [1:0]       rx_trig_sel,
   input logic [LVL_W-1:0] rx_level,
   input logic             err_overrun,
   input logic             err_parity,
   input logic             err_framing,
   input logic             err_break,
   input logic             lsr_rd,
   input logic [7:0]       iir,
   input logic             irq,
   input logic [7:0]       lsr
);
   // R1: nothing pending reads as the idle code
   a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> iir[5:0] == 6'h01);

   // R3: top two bits follow FIFO mode
   a_r3_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      iir[7:6] == {2{fifo_en}});

   // R2: an enabled line error outranks every other source
   a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[2] && lsr[4:1] != 4'h0) |-> iir[5:0] == 6'h06);

   // R9: a status read with no new error empties the sticky bits
   a_r9_lsr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !(err_overrun || err_parity || err_framing || err_break))
      |=> lsr[4:1] == 4'h0);

   // R5: receive data at the top threshold is reported unless a higher source wins
   a_r5_rx_trig: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[0] && fifo_en && rx_trig_sel == 2'd3 && int'(rx_level) >= DEPTH - 4
       && !(irq_en[2] && lsr[4:1] != 4'h0))
      |-> (iir[5:0] == 6'h04 || iir[5:0] == 6'h0C));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_en      (irq_en),
   .fifo_en     (fifo_en),
   .rx_trig_sel (rx_trig_sel),
   .rx_level    (rx_level),
   .err_overrun (err_overrun),
   .err_parity  (err_parity),
   .err_framing (err_framing),
   .err_break   (err_break),
   .lsr_rd      (lsr_rd),
   .iir         (iir),
   .irq         (irq),
   .lsr         (lsr)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/100ps
module sim_uart_irq_ident;
   localparam int DEPTH = 64;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] irq_en = '0;
   logic fifo_en = 1'b0;
   logic [1:0] rx_trig_sel = 2'd3, tx_trig_sel = 2'd3;
   logic tx_drain_mode = 1'b0;
   logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
   logic tx_shift_empty = 1'b1;
   logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
   logic rx_fifo_err = 0, rx_timeout = 0, modem_evt = 0, xoff_evt = 0, flow_evt = 0;
   logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, rx_rd = 0, thr_wr = 0;
   logic [7:0] iir, lsr, ssr;
   logic irq;

   always #2.5 clk = ~clk;

   uart_irq_ident #(.DEPTH(DEPTH)) u0 (.*);

   typedef struct {
      logic [7:0] iir;
      logic [7:0] lsr;
      logic [7:0] ssr;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   event mon_go;
   int checks = 0, failures = 0;
   bit done = 0;

   // monitor: pops each expected item and compares with the ports
   initial begin
      forever begin
         @(mon_go);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (iir !== e.iir || lsr !== e.lsr || ssr !== e.ssr || irq !== e.irq) begin
               failures++;
               $display("FAIL %s: iir=%02h lsr=%02h ssr=%02h irq=%0b expected iir=%02h lsr=%02h ssr=%02h irq=%0b",
                        e.tag, iir, lsr, ssr, irq, e.iir, e.lsr, e.ssr, e.irq);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      #0.5;
   endtask

   task automatic expect_now(input logic [7:0] ei, input logic [7:0] el,
                             input logic [7:0] es, input string tag);
      exp_t e;
      e.iir = ei; e.lsr = el; e.ssr = es; e.irq = ~ei[0]; e.tag = tag;
      exp_q.push_back(e);
      -> mon_go;
      #0.5;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1;
      tick();
      s = 1'b0;
      tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      expect_now(8'h01, 8'h60, 8'h00, "R1 reset idle");

      fifo_en = 1'b1; tick();
      expect_now(8'hC1, 8'h60, 8'h00, "R3 mirror");

      // receive data threshold 60
      irq_en = 6'h01; rx_level = 59; tick();
      expect_now(8'hC1, 8'h61, 8'h00, "R5 below 60");
      rx_level = 60; tick();
      expect_now(8'hC4, 8'h61, 8'h00, "R5 at 60 R13 same cycle");

      pulse(rx_timeout);
      expect_now(8'hCC, 8'h61, 8'h00, "R10 R2 timeout above rx data");
      pulse(rx_rd);
      expect_now(8'hC4, 8'h61, 8'h00, "R10 cleared by read");

      // line status
      irq_en = 6'h05;
      pulse(err_parity);
      expect_now(8'hC6, 8'h65, 8'h00, "R8 R2 parity error");
      err_overrun = 1; err_break = 1; rx_fifo_err = 1; tick();
      err_overrun = 0; err_break = 0; tick();
      expect_now(8'hC6, 8'hF7, 8'h00, "R8 overrun break fifo error");
      rx_fifo_err = 0;
      pulse(lsr_rd);
      expect_now(8'hC4, 8'h61, 8'h00, "R9 lsr read clears");
      lsr_rd = 1; err_framing = 1; tick();
      lsr_rd = 0; err_framing = 0; tick();
      expect_now(8'hC6, 8'h69, 8'h00, "R9 event wins over read");
      pulse(lsr_rd);
      expect_now(8'hC4, 8'h61, 8'h00, "R9 second clear");

      // transmit free space threshold 56
      rx_level = 0; irq_en = 6'h02; tx_level = 9; tick();
      expect_now(8'hC1, 8'h00, 8'h00, "R6 55 free");
      tx_level = 8; tick();
      expect_now(8'hC2, 8'h00, 8'h00, "R6 56 free");
      pulse(iir_rd);
      expect_now(8'hC1, 8'h00, 8'h00, "R6 iir read clears");
      tx_level = 9; tick();
      tx_level = 8; tick();
      expect_now(8'hC2, 8'h00, 8'h00, "R6 re-armed");
      pulse(thr_wr);
      expect_now(8'hC1, 8'h00, 8'h00, "R6 write clears");

      // drain mode
      tx_drain_mode = 1; tick();
      tx_level = 0; tx_shift_empty = 0; tick();
      expect_now(8'hC1, 8'h20, 8'h00, "R7 shift busy");
      tx_shift_empty = 1; tick();
      expect_now(8'hC2, 8'h60, 8'h00, "R7 drained");
      pulse(iir_rd);
      expect_now(8'hC1, 8'h60, 8'h00, "R7 cleared");

      // modem with enable off then on
      irq_en = 6'h00; tick();
      pulse(modem_evt);
      expect_now(8'hC1, 8'h60, 8'h00, "R4 disabled modem ignored");
      irq_en = 6'h08; tick();
      expect_now(8'hC0, 8'h60, 8'h00, "R4 latched modem shown");
      pulse(msr_rd);
      expect_now(8'hC1, 8'h60, 8'h00, "R11 msr read clears");

      // XOFF and flow change
      irq_en = 6'h30;
      pulse(xoff_evt);
      expect_now(8'hD0, 8'h60, 8'h00, "R2 xoff");
      pulse(flow_evt);
      expect_now(8'hD0, 8'h60, 8'h00, "R2 xoff above flow");
      pulse(iir_rd);
      expect_now(8'hE0, 8'h60, 8'h00, "R11 xoff cleared by iir read");
      pulse(iir_rd);
      expect_now(8'hC1, 8'h60, 8'h00, "R11 flow cleared by iir read");

      // supplementary status
      tx_level = 64; tick();
      expect_now(8'hC1, 8'h00, 8'h01, "R12 tx full");
      tx_level = 63; tick();
      expect_now(8'hC1, 8'h00, 8'h00, "R12 not full");

      // non-FIFO receive and low threshold
      tx_level = 0; fifo_en = 0; irq_en = 6'h01; rx_level = 1; tick();
      expect_now(8'h04, 8'h61, 8'h00, "R5 non-FIFO one char");
      fifo_en = 1; rx_trig_sel = 2'd0; rx_level = 7; tick();
      expect_now(8'hC1, 8'h61, 8'h00, "R5 sel0 below 8");
      rx_level = 8; tick();
      expect_now(8'hC4, 8'h61, 8'h00, "R5 sel0 at 8");

      // everything enabled, line error on top
      irq_en = 6'h3F; tick();
      pulse(err_overrun);
      expect_now(8'hC6, 8'h63, 8'h00, "R2 line error top with all enabled");

      tick();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule